// File: doc/BRIEF.md
# Tile power-gating sequence controller

This block sequences the power-down and wake-up of one processor tile. Software drives it through a small 32-bit register interface. It first asks for preparation and waits for that acknowledge. It then asks for gating and waits for that acknowledge. The actual power-down starts only when the core signals that it has ceased execution. While each request is open, the controller gathers failure reports from the power-management controller and from the tile into sticky per-cause bits. A wake that arrives during preparation marks the attempt as aborted.

When the tile is gated, an enabled wake source (software or external interrupt) brings it back. Power is restored first and isolation is released one cycle later. On that same cycle the controller drives a one-cycle warm-reset pulse and presents the stored 64-bit resume address to the core. Software can then read back that a warm reset took place.

Top module: `tile_pg_ctrl`

## Requirements
- R1: After reset, every register reads zero except the wake-mask register, which reads 0x0000_0003. The outputs pwr_gate, iso_en, warm_rst and resume_pc are zero.
- R2: In the preparation (0x00) and gate (0x04) registers, writing bit 31 sets request bit 31 and clears acknowledge bit 30 and the disable pair. Bit 30 rises exactly ACK_DLY cycles later. Writing bit 29 sets disable request bit 29 and clears the enable pair, and disable acknowledge bit 28 follows in the same way. If bits 31 and 29 are written together, the disable request wins.
- R3: While its enable request is set and the sequencer is idle, the preparation register collects failure causes. The bits are 18 (cache flush busy), 17 (power-controller enable error), 16 (power-controller deny), 15 (bus error) and 12 (wake seen). These bits are sticky across a disable request and are cleared only by the next enable request.
- R4: A wake during a pending preparation enable request sets abort bit 2. Bit 2 reads as 1 only once bit 30 is set.
- R5: The gate register collects its own causes while its enable request is set: 17 (enable error), 16 (deny), 15 (bus error) and 14 (bus master busy). Bit 1 reads 1 after a wake from the gated state and clears on the next gate enable request.
- R6: Writes to the preparation or gate register that set neither bit 31 nor bit 29 change nothing.
- R7: The resume address low word at 0x10 and high word at 0x14 read back what was written.
- R8: At 0x20, writing with bit 31 set loads the wake mask from bits 1:0 (bit 0 software wake, bit 1 external wake), sets bit 31 and raises bit 30 ACK_DLY cycles later. Writing with bit 31 clear drops bits 31 and 30 and leaves the mask unchanged. A masked wake source does not wake a gated tile.
- R9: Power-down begins only when both enable acknowledges are set, no failure or abort bit is set, and core_cease is high. iso_en rises on the next clock edge, and pwr_gate rises one edge after that.
- R10: An enabled wake while gated drops pwr_gate on the next edge. One edge later iso_en drops, warm_rst pulses for one cycle and resume_pc shows {high word, low word}. All request and acknowledge bits then read zero.
- R11: bus_ready is high in the cycle after each read or write. Read data arrives with it, and unmapped addresses read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Register byte address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_ready |
| bus_ready | output | 1 | Access complete |
| core_cease | input | 1 | Core has stopped execution |
| wake_sw | input | 1 | Software interrupt wake source |
| wake_ext | input | 1 | External interrupt wake source |
| pmc_deny | input | 1 | Power controller refuses the request |
| pmc_ena_err | input | 1 | Power controller enable error |
| pmc_bus_err | input | 1 | Bus error during the sequence |
| flush_busy | input | 1 | Private cache flush not quiescent |
| mast_busy | input | 1 | Tile bus master not quiescent |
| pwr_gate | output | 1 | Power-gate request to the tile switches |
| iso_en | output | 1 | Isolation request for tile outputs |
| warm_rst | output | 1 | One-cycle warm-reset pulse on wake |
| resume_pc | output | 64 | Resume address presented on wake |

## Verification
The bench checks that an acknowledge is still low just after its request. A design that acknowledges at once would let software skip the wait. A wake pulse during preparation must raise the wake-seen cause at once, while the abort bit stays hidden until the acknowledge; exposing it early, or losing it, makes those reads differ. The bench also checks that a deny response is still present after a disable request and disappears on the next enable request. A design that is not sticky, or that clears on the wrong write, fails those reads. Finally, a masked external wake must leave the tile gated, and the release order, the warm pulse and the resume address are checked cycle by cycle.

// File: rtl/pg_pkg.sv
package pg_pkg;
  localparam int REG_W = 32;

  // register byte offsets
  localparam logic [7:0] OFS_PREP   = 8'h00;
  localparam logic [7:0] OFS_GATE   = 8'h04;
  localparam logic [7:0] OFS_PC_LO  = 8'h10;
  localparam logic [7:0] OFS_PC_HI  = 8'h14;
  localparam logic [7:0] OFS_WMASK  = 8'h20;

  // handshake bit positions shared by the channels
  localparam int B_ENA_REQ = 31;
  localparam int B_ENA_ACK = 30;
  localparam int B_DIS_REQ = 29;
  localparam int B_DIS_ACK = 28;
  localparam int B_ABORT   = 2;
  localparam int B_WARM    = 1;

  localparam int PREP_ERR_W = 5;
  localparam int GATE_ERR_W = 4;

  typedef enum logic [2:0] {
    S_RUN, S_ISO, S_GATED, S_UNGATE, S_RESTORE
  } seq_t;
endpackage

// File: rtl/pg_hs_chan.sv
module pg_hs_chan #(
  parameter int ERR_W   = 4,
  parameter int ACK_DLY = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_ena,
  input  logic             wr_dis,
  input  logic             clr,
  input  logic [ERR_W-1:0] err_in,
  input  logic             wake_in,
  output logic             ena_req,
  output logic             ena_ack,
  output logic             dis_req,
  output logic             dis_ack,
  output logic [ERR_W-1:0] err,
  output logic             abort
);
  localparam int CNT_W = $clog2(ACK_DLY + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(ACK_DLY);

  logic [CNT_W-1:0] cnt;
  logic             pend;

  assign pend = (ena_req & ~ena_ack) | (dis_req & ~dis_ack);

  always_ff @(posedge clk) begin
    if (rst) begin
      ena_req <= 1'b0; ena_ack <= 1'b0;
      dis_req <= 1'b0; dis_ack <= 1'b0;
      err     <= '0;   abort   <= 1'b0;
      cnt     <= '0;
    end else if (clr) begin
      ena_req <= 1'b0; ena_ack <= 1'b0;
      dis_req <= 1'b0; dis_ack <= 1'b0;
      cnt     <= '0;
    end else if (wr_dis) begin
      dis_req <= 1'b1; dis_ack <= 1'b0;
      ena_req <= 1'b0; ena_ack <= 1'b0;
      cnt     <= CNT_LOAD;
    end else if (wr_ena) begin
      ena_req <= 1'b1; ena_ack <= 1'b0;
      dis_req <= 1'b0; dis_ack <= 1'b0;
      err     <= '0;   abort   <= 1'b0;
      cnt     <= CNT_LOAD;
    end else begin
      if (pend) begin
        if (cnt == CNT_W'(1)) begin
          if (ena_req) ena_ack <= 1'b1;
          if (dis_req) dis_ack <= 1'b1;
        end
        cnt <= cnt - CNT_W'(1);
      end
      if (ena_req) begin
        err <= err | err_in;
        if (!ena_ack && wake_in) abort <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/pg_seq.sv
module pg_seq import pg_pkg::*; #(
  parameter int PC_W = 64
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            go,
  input  logic            wake,
  input  logic [PC_W-1:0] pc_in,
  output logic            pwr_gate,
  output logic            iso_en,
  output logic            warm_rst,
  output logic [PC_W-1:0] resume_pc,
  output logic            idle,
  output logic            wake_done
);
  seq_t st, nxt;

  always_comb begin
    nxt = st;
    case (st)
      S_RUN:     if (go) nxt = S_ISO;
      S_ISO:     nxt = S_GATED;
      S_GATED:   if (wake) nxt = S_UNGATE;
      S_UNGATE:  nxt = S_RESTORE;
      S_RESTORE: nxt = S_RUN;
      default:   nxt = S_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_RUN;
      pwr_gate  <= 1'b0;
      iso_en    <= 1'b0;
      warm_rst  <= 1'b0;
      resume_pc <= '0;
    end else begin
      st       <= nxt;
      pwr_gate <= (nxt == S_GATED);
      iso_en   <= (nxt == S_ISO) || (nxt == S_GATED) || (nxt == S_UNGATE);
      warm_rst <= (nxt == S_RESTORE);
      if (nxt == S_RESTORE) resume_pc <= pc_in;
    end
  end

  assign idle      = (st == S_RUN);
  assign wake_done = (st == S_RESTORE);
endmodule

// File: rtl/tile_pg_ctrl.sv
module tile_pg_ctrl import pg_pkg::*; #(
  parameter int ADDR_W  = 8,
  parameter int ACK_DLY = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              bus_ready,
  input  logic              core_cease,
  input  logic              wake_sw,
  input  logic              wake_ext,
  input  logic              pmc_deny,
  input  logic              pmc_ena_err,
  input  logic              pmc_bus_err,
  input  logic              flush_busy,
  input  logic              mast_busy,
  output logic              pwr_gate,
  output logic              iso_en,
  output logic              warm_rst,
  output logic [63:0]       resume_pc
);
  localparam int PC_W  = 2 * REG_W;
  localparam int CNT_W = $clog2(ACK_DLY + 1);

  logic sel_prep, sel_gate, sel_lo, sel_hi, sel_wm;
  assign sel_prep = bus_addr == ADDR_W'(OFS_PREP);
  assign sel_gate = bus_addr == ADDR_W'(OFS_GATE);
  assign sel_lo   = bus_addr == ADDR_W'(OFS_PC_LO);
  assign sel_hi   = bus_addr == ADDR_W'(OFS_PC_HI);
  assign sel_wm   = bus_addr == ADDR_W'(OFS_WMASK);

  logic seq_idle, wake_done, wake_raw, wake_en, go;
  logic [1:0] wmask;
  logic wm_req, wm_ack;
  logic [CNT_W-1:0] wm_cnt;
  logic [REG_W-1:0] pc_lo, pc_hi;
  logic warm_q;

  logic prep_ena_req, prep_ena_ack, prep_dis_req, prep_dis_ack, prep_abort;
  logic gate_ena_req, gate_ena_ack, gate_dis_req, gate_dis_ack, gate_abort;
  logic [PREP_ERR_W-1:0] prep_err, prep_err_in;
  logic [GATE_ERR_W-1:0] gate_err, gate_err_in;

  assign wake_raw = wake_sw | wake_ext;
  assign wake_en  = (wake_sw & wmask[0]) | (wake_ext & wmask[1]);

  // cause order: flush, enable error, deny, bus error, wake
  assign prep_err_in = {flush_busy, pmc_ena_err, pmc_deny, pmc_bus_err, wake_raw}
                       & {PREP_ERR_W{seq_idle}};
  assign gate_err_in = {pmc_ena_err, pmc_deny, pmc_bus_err, mast_busy}
                       & {GATE_ERR_W{seq_idle}};

  pg_hs_chan #(.ERR_W(PREP_ERR_W), .ACK_DLY(ACK_DLY)) prep_i (
    .clk(clk), .rst(rst),
    .wr_ena(bus_wr & sel_prep & bus_wdata[B_ENA_REQ]),
    .wr_dis(bus_wr & sel_prep & bus_wdata[B_DIS_REQ]),
    .clr(wake_done), .err_in(prep_err_in), .wake_in(wake_raw & seq_idle),
    .ena_req(prep_ena_req), .ena_ack(prep_ena_ack),
    .dis_req(prep_dis_req), .dis_ack(prep_dis_ack),
    .err(prep_err), .abort(prep_abort));

  pg_hs_chan #(.ERR_W(GATE_ERR_W), .ACK_DLY(ACK_DLY)) gate_i (
    .clk(clk), .rst(rst),
    .wr_ena(bus_wr & sel_gate & bus_wdata[B_ENA_REQ]),
    .wr_dis(bus_wr & sel_gate & bus_wdata[B_DIS_REQ]),
    .clr(wake_done), .err_in(gate_err_in), .wake_in(1'b0),
    .ena_req(gate_ena_req), .ena_ack(gate_ena_ack),
    .dis_req(gate_dis_req), .dis_ack(gate_dis_ack),
    .err(gate_err), .abort(gate_abort));

  assign go = prep_ena_ack & gate_ena_ack & ~(|prep_err) & ~(|gate_err)
              & ~prep_abort & ~gate_abort & core_cease;

  pg_seq #(.PC_W(PC_W)) seq_i (
    .clk(clk), .rst(rst), .go(go), .wake(wake_en), .pc_in({pc_hi, pc_lo}),
    .pwr_gate(pwr_gate), .iso_en(iso_en), .warm_rst(warm_rst),
    .resume_pc(resume_pc), .idle(seq_idle), .wake_done(wake_done));

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_lo  <= '0; pc_hi <= '0;
      wmask  <= 2'b11; wm_req <= 1'b0; wm_ack <= 1'b0; wm_cnt <= '0;
      warm_q <= 1'b0;
    end else begin
      if (bus_wr && sel_lo) pc_lo <= bus_wdata;
      if (bus_wr && sel_hi) pc_hi <= bus_wdata;
      if (bus_wr && sel_wm) begin
        wm_ack <= 1'b0;
        wm_req <= bus_wdata[B_ENA_REQ];
        if (bus_wdata[B_ENA_REQ]) begin
          wmask  <= bus_wdata[1:0];
          wm_cnt <= CNT_W'(ACK_DLY);
        end
      end else if (wm_req && !wm_ack) begin
        if (wm_cnt == CNT_W'(1)) wm_ack <= 1'b1;
        wm_cnt <= wm_cnt - CNT_W'(1);
      end
      if (wake_done) warm_q <= 1'b1;
      else if (bus_wr && sel_gate && bus_wdata[B_ENA_REQ] && !bus_wdata[B_DIS_REQ])
        warm_q <= 1'b0;
    end
  end

  logic [31:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    if (sel_prep) begin
      rd_mux[31:28] = {prep_ena_req, prep_ena_ack, prep_dis_req, prep_dis_ack};
      rd_mux[18:15] = prep_err[4:1];
      rd_mux[12]    = prep_err[0];
      rd_mux[B_ABORT] = prep_abort & prep_ena_ack;
    end else if (sel_gate) begin
      rd_mux[31:28] = {gate_ena_req, gate_ena_ack, gate_dis_req, gate_dis_ack};
      rd_mux[17:14] = gate_err;
      rd_mux[B_WARM] = warm_q;
    end else if (sel_lo) begin
      rd_mux = pc_lo;
    end else if (sel_hi) begin
      rd_mux = pc_hi;
    end else if (sel_wm) begin
      rd_mux[31:30] = {wm_req, wm_ack};
      rd_mux[1:0]   = wmask;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_ready <= 1'b0;
      bus_rdata <= '0;
    end else begin
      bus_ready <= bus_rd | bus_wr;
      bus_rdata <= bus_rd ? rd_mux : '0;
    end
  end
endmodule

// File: rtl/tile_pg_chk.sv
module tile_pg_chk (
  input logic clk,
  input logic rst,
  input logic pwr_gate,
  input logic iso_en,
  input logic warm_rst,
  input logic core_cease,
  input logic prep_req,
  input logic prep_ack,
  input logic gate_req,
  input logic gate_ack
);
  // R9
  gate_needs_iso_chk: assert property (@(posedge clk) disable iff (rst)
    pwr_gate |-> iso_en);
  // R9
  iso_before_gate_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(pwr_gate) |-> $past(iso_en));
  // R9
  iso_entry_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(iso_en) |-> ($past(core_cease) && $past(prep_ack) && $past(gate_ack)));
  // R10
  iso_release_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(iso_en) |-> (!$past(pwr_gate) && warm_rst));
  // R10
  warm_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    warm_rst |=> !warm_rst);
  // R2
  prep_ack_req_chk: assert property (@(posedge clk) disable iff (rst)
    prep_ack |-> prep_req);
  // R2
  gate_ack_req_chk: assert property (@(posedge clk) disable iff (rst)
    gate_ack |-> gate_req);
endmodule

bind tile_pg_ctrl tile_pg_chk chk_i (
  .clk(clk), .rst(rst), .pwr_gate(pwr_gate), .iso_en(iso_en),
  .warm_rst(warm_rst), .core_cease(core_cease),
  .prep_req(prep_ena_req), .prep_ack(prep_ena_ack),
  .gate_req(gate_ena_req), .gate_ack(gate_ena_ack));

// File: tb/tile_pg_ctrl_tb_top.sv
module tile_pg_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_ready;
  logic core_cease = 0, wake_sw = 0, wake_ext = 0;
  logic pmc_deny = 0, pmc_ena_err = 0, pmc_bus_err = 0, flush_busy = 0, mast_busy = 0;
  logic pwr_gate, iso_en, warm_rst;
  logic [63:0] resume_pc;

  int checks = 0, errors = 0;
  bit done = 0;
  logic last_ready;
  logic [31:0] rv;

  always #5 clk = ~clk;

  tile_pg_ctrl dut_i (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ready(bus_ready),
    .core_cease(core_cease), .wake_sw(wake_sw), .wake_ext(wake_ext),
    .pmc_deny(pmc_deny), .pmc_ena_err(pmc_ena_err), .pmc_bus_err(pmc_bus_err),
    .flush_busy(flush_busy), .mast_busy(mast_busy),
    .pwr_gate(pwr_gate), .iso_en(iso_en), .warm_rst(warm_rst), .resume_pc(resume_pc));

  // reset-state table: {address, expected read value}
  localparam logic [39:0] RST_TBL [6] = '{
    {8'h00, 32'h0000_0000}, {8'h04, 32'h0000_0000}, {8'h10, 32'h0000_0000},
    {8'h14, 32'h0000_0000}, {8'h20, 32'h0000_0003}, {8'h08, 32'h0000_0000}};

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
    last_ready = bus_ready;
  endtask

  task automatic poll(input logic [7:0] a, input int b, output logic [31:0] d);
    d = '0;
    for (int i = 0; i < 64; i++) begin
      rd(a, d);
      if (d[b]) break;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 outputs after reset
    chk("R1 outputs", {pwr_gate, iso_en, warm_rst, bus_ready}, 4'b0000);
    chk("R1 resume_pc", resume_pc, 64'h0);

    // R1 / R11 reset table
    for (int i = 0; i < 6; i++) begin
      rd(RST_TBL[i][39:32], rv);
      chk("R1 R11 reset read", rv, RST_TBL[i][31:0]);
    end
    chk("R11 ready after read", last_ready, 1'b1);

    // R7 resume address
    wr(8'h10, 32'h8000_1234);
    wr(8'h14, 32'h0000_00AB);
    rd(8'h10, rv); chk("R7 low word", rv, 32'h8000_1234);
    rd(8'h14, rv); chk("R7 high word", rv, 32'h0000_00AB);

    // R2 acknowledge is not immediate
    wr(8'h00, 32'h8000_0000);
    rd(8'h00, rv); chk("R2 ack pending", rv, 32'h8000_0000);
    poll(8'h00, 30, rv); chk("R2 prep acked", rv, 32'hC000_0000);

    // R8 wake mask: software wake only
    wr(8'h20, 32'h8000_0001);
    poll(8'h20, 30, rv); chk("R8 mask acked", rv, 32'hC000_0001);

    // R5 gate handshake
    wr(8'h04, 32'h8000_0000);
    poll(8'h04, 30, rv); chk("R5 gate acked", rv, 32'hC000_0000);

    // R9 power down
    core_cease = 1'b1;
    @(negedge clk);
    chk("R9 iso first", {iso_en, pwr_gate}, 2'b10);
    @(negedge clk);
    chk("R9 gated", {iso_en, pwr_gate}, 2'b11);
    core_cease = 1'b0;
    wake_ext = 1'b1;
    repeat (3) @(negedge clk);
    chk("R8 masked wake ignored", {iso_en, pwr_gate}, 2'b11);
    wake_ext = 1'b0;

    // R10 wake sequence
    wake_sw = 1'b1;
    @(negedge clk);
    wake_sw = 1'b0;
    chk("R10 power restored", {iso_en, pwr_gate, warm_rst}, 3'b100);
    @(negedge clk);
    chk("R10 iso released", {iso_en, pwr_gate, warm_rst}, 3'b001);
    chk("R10 resume pc", resume_pc, 64'h0000_00AB_8000_1234);
    @(negedge clk);
    chk("R10 warm pulse ends", warm_rst, 1'b0);
    rd(8'h04, rv); chk("R5 R10 warm bit", rv, 32'h0000_0002);
    rd(8'h00, rv); chk("R10 prep cleared", rv, 32'h0000_0000);

    // R3 deny case
    wr(8'h00, 32'h8000_0000);
    pmc_deny = 1'b1;
    @(negedge clk);
    pmc_deny = 1'b0;
    poll(8'h00, 30, rv); chk("R3 deny captured", rv, 32'hC001_0000);
    wr(8'h04, 32'h8000_0000);
    poll(8'h04, 30, rv); chk("R5 warm cleared", rv, 32'hC000_0000);
    core_cease = 1'b1;
    repeat (3) @(negedge clk);
    chk("R9 blocked by deny", {iso_en, pwr_gate}, 2'b00);
    core_cease = 1'b0;
    wr(8'h00, 32'hA000_0000);
    rd(8'h00, rv); chk("R2 disable wins", rv[31:28], 4'b0010);
    poll(8'h00, 28, rv); chk("R3 sticky after disable", rv, 32'h3001_0000);
    wr(8'h00, 32'h5007_9004);
    rd(8'h00, rv); chk("R6 write ignored", rv, 32'h3001_0000);
    wr(8'h00, 32'h8000_0000);
    rd(8'h00, rv); chk("R3 cleared on enable", rv, 32'h8000_0000);

    // R4 wake during preparation
    wr(8'h00, 32'h8000_0000);
    wake_ext = 1'b1;
    @(negedge clk);
    wake_ext = 1'b0;
    rd(8'h00, rv); chk("R4 abort hidden", rv, 32'h8000_1000);
    poll(8'h00, 30, rv); chk("R4 abort shown", rv, 32'hC000_1004);
    core_cease = 1'b1;
    repeat (3) @(negedge clk);
    chk("R4 no gating after abort", {iso_en, pwr_gate}, 2'b00);
    core_cease = 1'b0;

    // R5 gate cause bit 14
    wr(8'h04, 32'h8000_0000);
    mast_busy = 1'b1;
    @(negedge clk);
    mast_busy = 1'b0;
    poll(8'h04, 30, rv); chk("R5 master busy", rv, 32'hC000_4000);

    // R8 mask request drop
    wr(8'h20, 32'h0000_0000);
    rd(8'h20, rv); chk("R8 request dropped", rv, 32'h0000_0001);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule